// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block serialises bytes onto a single line in asynchronous frames. A producer hands a byte to a one-entry holding register, and an independent shift register sends it out. The byte leaves the holding register in the same cycle that its start bit begins. A second byte can therefore be queued while the first frame is still on the line. When a frame ends and a byte is waiting, the next frame follows with no idle gap.

The frame format is set at run time through four plain control pins. The data length is the full word or one bit shorter, there are one or two stop bits, and parity can be odd, even or absent. The line idles high. A frame is one low start bit, then the data least significant bit first, then the optional parity bit, then the high stop bits. Each bit lasts `TICKS_PER_BIT` pulses of an external baud-rate enable. The format pins are captured when a frame is loaded, so changing them during a frame has no effect until the next one.

The input side is a valid/ready pair. `in_ready` is the buffer-empty flag and is high whenever the holding register is free. The producer should wait for `in_ready` before it asserts `in_valid`. If it does not, there is no stall: the new byte replaces the pending one. `tx_en` gates the whole transmitter. Turning it off in the middle of a frame is not a supported use.

Top module: `buffered_serial_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: Each frame begins with exactly one low start bit and sends the data least significant bit first. Every bit lasts `TICKS_PER_BIT` (default 16) `baud_tick` pulses.
- R3: With `cfg_eight`=1 the frame carries 8 data bits. With `cfg_eight`=0 it carries 7, and `in_data[7]` is ignored.
- R4: With `cfg_two_stop`=1 the frame ends with two high stop bits. With `cfg_two_stop`=0 it ends with one.
- R5: With `cfg_par_en`=1 a parity bit follows the data. With `cfg_par_odd`=1 the count of ones in data plus parity is odd; with `cfg_par_odd`=0 it is even.
- R6: With `cfg_par_en`=0 no parity bit is sent, and `cfg_par_odd` has no effect on the frame.
- R7: An accepted write drives `in_ready` low in the following cycle. `in_ready` returns to 1 in exactly the cycle in which `txd` goes low for that byte's start bit.
- R8: If a byte is pending when the last stop bit ends, its start bit begins in the very next cycle, with no idle bit time between frames.
- R9: A write made while `in_ready` is 0 replaces the pending byte. Only the most recent byte is sent.
- R10: While `tx_en` is 0 and no frame is in progress, no frame starts and the pending byte is kept. The byte is sent once `tx_en` returns to 1.
- R11: `busy` is 1 from the first cycle of the start bit to the end of the last stop bit, and 0 otherwise. While `busy` is 0, `txd` is 1.
- R12: The format pins are sampled when a frame is loaded. Changes made during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | Baud-rate enable pulse; `TICKS_PER_BIT` pulses make one bit |
| cfg_eight | input | 1 | 1: full-width data, 0: one bit shorter |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_par_en | input | 1 | 1: append parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| in_valid | input | 1 | Byte write strobe |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial line output |
| busy | output | 1 | Frame in progress |

## Verification
The bench sweeps all sixteen format combinations over data patterns that include 0x80 and 0x7F. A design that failed to mask the top bit in short mode, placed parity wrongly or inverted its sense, or miscounted stop bits would corrupt a sampled bit or leave `busy` high too long. Back-to-back and overwrite sequences expose a design that inserts an idle gap between frames or sends a stale pending byte. An exact cycle check on `in_ready` catches an empty flag that rises too early or too late relative to the start bit. A format change made during a frame, and a write made while `tx_en` is low, catch designs that sample the format pins live or that start a frame without the enable.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic eight;
    logic two_stop;
    logic par_en;
    logic par_odd;
  } sertx_cfg_t;
endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  // A write in the same cycle as a take refills the slot; take sees the old data.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = DW + 4,
  parameter int LW = 4
) (
  input  logic [DW-1:0] data,
  input  sertx_cfg_t    cfg,
  output logic [FW-1:0] frame,
  output logic [LW-1:0] len
);
  logic [DW-1:0] d;
  logic [LW-1:0] nd;
  logic [LW-1:0] ppos;
  logic          par;

  always_comb begin
    d = data;
    if (!cfg.eight) d[DW-1] = 1'b0;
    par  = (^d) ^ cfg.par_odd;
    nd   = cfg.eight ? LW'(DW) : LW'(DW - 1);
    ppos = nd + LW'(1);
    // Unused upper positions default to 1, which forms the stop bits.
    frame = '1;
    frame[0] = 1'b0;
    frame[DW:1] = d;
    if (!cfg.eight) frame[DW] = 1'b1;
    if (cfg.par_en) frame[ppos] = par;
    len = LW'(1) + nd + LW'(cfg.par_en) + (cfg.two_stop ? LW'(2) : LW'(1));
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int FW  = 12,
  parameter int LW  = 4,
  parameter int TPB = 16,
  parameter int TW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tick,
  input  logic          have_data,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] len,
  output logic          take,
  output logic          txd,
  output logic          busy
);
  logic [FW-1:0] sh;
  logic [LW-1:0] left;
  logic [TW-1:0] tcnt;
  logic          step;
  logic          bit_end;
  logic          last;

  assign step    = busy & tx_en & tick;
  assign bit_end = step & (tcnt == TW'(TPB - 1));
  assign last    = (left == '0);
  assign take    = tx_en & have_data & (~busy | (bit_end & last));
  assign txd     = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else if (take) begin
      busy <= 1'b1;
      sh   <= frame;
      left <= len - LW'(1);
      tcnt <= '0;
    end else if (bit_end) begin
      tcnt <= '0;
      if (last) begin
        busy <= 1'b0;
      end else begin
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - LW'(1);
      end
    end else if (step) begin
      tcnt <= tcnt + TW'(1);
    end
  end
endmodule

// File: rtl/buffered_serial_tx.sv
module buffered_serial_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              cfg_eight,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int TICK_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  sertx_cfg_t          cfg;
  logic                full;
  logic                take;
  logic [DATA_W-1:0]   held;
  logic [FRAME_W-1:0]  frame;
  logic [LEN_W-1:0]    len;

  assign cfg      = '{eight: cfg_eight, two_stop: cfg_two_stop,
                      par_en: cfg_par_en, par_odd: cfg_par_odd};
  assign in_ready = ~full;

  sertx_holdbuf #(.DW(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(in_valid), .wr_data(in_data),
    .take(take), .full(full), .data(held)
  );

  sertx_framer #(.DW(DATA_W), .FW(FRAME_W), .LW(LEN_W)) u_framer (
    .data(held), .cfg(cfg), .frame(frame), .len(len)
  );

  sertx_shifter #(.FW(FRAME_W), .LW(LEN_W), .TPB(TICKS_PER_BIT), .TW(TICK_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tick(baud_tick),
    .have_data(full), .frame(frame), .len(len),
    .take(take), .txd(txd), .busy(busy)
  );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy
);
  a_r11_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  a_r11_start_low_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  a_r7_ready_drops_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_ready);
  a_r7_ready_rises_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (busy && !txd));
  a_r10_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);
  a_r10_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && busy) |=> (busy && $stable(txd)));
endmodule

bind buffered_serial_tx sertx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .busy(busy)
);

// File: tb/buffered_serial_tx_tb.sv
`timescale 1ns/1ps
module buffered_serial_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1;
  logic baud_tick = 1'b1;
  logic c_eight = 1'b1, c_two = 1'b0, c_pen = 1'b0, c_podd = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, txd, busy;
  int checks = 0;
  int errors = 0;
  int tp = 1;
  int ph = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    baud_tick = (ph == 0);
    ph = (ph + 1 >= tp) ? 0 : ph + 1;
  end

  buffered_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .cfg_eight(c_eight), .cfg_two_stop(c_two), .cfg_par_en(c_pen),
    .cfg_par_odd(c_podd), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .busy(busy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Receives one frame, comparing it with a frame built from the requirements.
  task automatic rx_check(input logic [7:0] d, input bit expect_idle, input string tag);
    logic [15:0] bits;
    string       btag [16];
    int nd, len, ones, idx, bl, guard;
    nd = c_eight ? 8 : 7;
    bits = '1;
    bits[0] = 1'b0; btag[0] = "R2";
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      bits[1 + i] = d[i];
      btag[1 + i] = "R3";
      ones += d[i];
    end
    idx = 1 + nd;
    if (c_pen) begin
      bits[idx] = c_podd ? ~ones[0] : ones[0];
      btag[idx] = "R5";
      idx++;
    end
    btag[idx] = c_pen ? "R4" : "R6";
    len = idx + (c_two ? 2 : 1);
    for (int i = idx + 1; i < len; i++) btag[i] = "R4";
    bl = 16 * tp;
    guard = 0;
    while (txd !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (bl / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      chk(txd === bits[i], {tag, " ", btag[i]}, int'(txd), int'(bits[i]));
      chk(busy === 1'b1, {tag, " R11 busy"}, int'(busy), 1);
      if (i < len - 1) repeat (bl) @(negedge clk);
    end
    repeat (bl - bl / 2) @(negedge clk);
    if (expect_idle) begin
      if (tp > 1) repeat (tp) @(negedge clk);
      chk(busy === 1'b0 && txd === 1'b1, {tag, " R11 end"}, int'({busy, txd}), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h7F, 8'h01};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);

    // Sweep all formats (R2..R6)
    for (int c = 0; c < 16; c++) begin
      {c_eight, c_two, c_pen, c_podd} = 4'(c);
      for (int p = 0; p < 7; p++) begin
        write_byte(pats[p]);
        rx_check(pats[p], 1'b1, "sweep");
      end
    end

    // R7 exact empty-flag timing, then R8 back-to-back
    {c_eight, c_two, c_pen, c_podd} = 4'b1011;
    write_byte(8'hC3);
    chk(in_ready === 1'b0, "R7 low after write", int'(in_ready), 0);
    @(negedge clk);
    chk(in_ready === 1'b1 && txd === 1'b0, "R7 high with start", int'({in_ready, txd}), 2);
    fork
      rx_check(8'hC3, 1'b0, "R8 first");
      write_byte(8'h3C);
    join
    chk(txd === 1'b0 && busy === 1'b1, "R8 no gap", int'({txd, busy}), 1);
    chk(in_ready === 1'b1, "R8 R7 buffer emptied at start", int'(in_ready), 1);
    rx_check(8'h3C, 1'b1, "R8 second");

    // R9 overwrite of pending byte
    {c_eight, c_two, c_pen, c_podd} = 4'b1100;
    write_byte(8'h11);
    fork
      rx_check(8'h11, 1'b0, "R9 first");
      begin
        repeat (4) @(negedge clk);
        write_byte(8'h22);
        write_byte(8'h99);
      end
    join
    rx_check(8'h99, 1'b1, "R9 replaced");

    // R10 disabled transmitter holds the byte
    tx_en = 1'b0;
    write_byte(8'h6D);
    begin
      bit held_ok = 1'b1;
      for (int i = 0; i < 60; i++) begin
        if (txd !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b0) held_ok = 1'b0;
        @(negedge clk);
      end
      chk(held_ok, "R10 idle while off", int'(held_ok), 1);
    end
    tx_en = 1'b1;
    rx_check(8'h6D, 1'b1, "R10 sent after enable");

    // R12 format change during a frame
    {c_eight, c_two, c_pen, c_podd} = 4'b1010;
    write_byte(8'hB4);
    fork
      rx_check(8'hB4, 1'b0, "R12");
      begin
        repeat (20) @(negedge clk);
        {c_eight, c_two, c_pen, c_podd} = 4'b0101;
      end
    join
    {c_eight, c_two, c_pen, c_podd} = 4'b1010;
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && txd === 1'b1, "R12 R11 idle after", int'({busy, txd}), 1);

    // R2 slower baud ticks
    tp = 3;
    {c_eight, c_two, c_pen, c_podd} = 4'b1110;
    repeat (3) @(negedge clk);
    write_byte(8'h96);
    rx_check(8'h96, 1'b1, "R2 slow tick");
    {c_eight, c_two, c_pen, c_podd} = 4'b0011;
    write_byte(8'hE9);
    rx_check(8'hE9, 1'b1, "R2 slow tick short");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule